// File: doc/BRIEF.md
# Quiescent Current Measurement Sequencer

This block runs one supply-current measurement on a device whose scan chain has just been filled with a test vector. When the scan shift logic reports that a vector is fully in place, the sequencer drops the functional clock enable. With the clock held off, the circuit sits in a static, known state. The block then counts out a programmable settling interval on its free-running reference clock, sends a one-cycle sample request to an external current digitizer, and waits for the digitized code.

The returned code counts 1 µA per LSB. It is compared against a programmable limit. A typical setup uses a 75 µA limit and a settling count equal to 30 ms of reference clock. A result of pass or fail is reported with a one-cycle done strobe, and the functional clock is then enabled again. If the digitizer never answers, the vector is marked failed with a timeout flag.

Top module: `qcm_sequencer`

## Requirements
- R1: A high `vecLoaded` seen while idle (`funcClkEn` high) drives `funcClkEn` low in the next cycle. `vecLoaded` seen at any other time is ignored.
- R2: `funcClkEn` stays low from the clock stop through the settle, sample, wait, compare and done cycles. It returns high in the cycle after `done`.
- R3: `sampleReq` is a one-cycle pulse that rises exactly max(`settleCycles`,1)+1 cycles after `funcClkEn` falls. A `settleCycles` value of 0 acts as 1.
- R4: The code is compared as an unsigned number at 1 µA per LSB. `fail` is set when the accepted code is strictly greater than `limitCode`. A code equal to the limit passes, and `pass` is always the inverse of `fail` once a result exists.
- R5: `sampleValid` is accepted only in a window of `TIMEOUT_CYCLES` cycles starting the cycle after `sampleReq`. A valid pulse outside that window has no effect on the result. If no valid pulse arrives within the window, `timeoutErr` and `fail` are both set.
- R6: `done` is a one-cycle pulse two cycles after the accepting cycle (or after the last window cycle on timeout). `pass`, `fail` and `timeoutErr` are valid with `done` and hold until the next clock stop, which clears them.
- R7: A synchronous `rst` returns the block to idle with `funcClkEn` high and `sampleReq`, `done`, `pass`, `fail` and `timeoutErr` low, from any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst | input | 1 | Synchronous reset, active high |
| vecLoaded | input | 1 | Scan vector fully applied |
| settleCycles | input | CNT_W | Settling interval in reference clock cycles |
| limitCode | input | CODE_W | Pass limit, 1 µA per LSB |
| sampleData | input | CODE_W | Digitized current code |
| sampleValid | input | 1 | Digitizer data valid strobe |
| funcClkEn | output | 1 | Functional clock enable |
| sampleReq | output | 1 | Sample request pulse to digitizer |
| done | output | 1 | Measurement complete strobe |
| pass | output | 1 | Result within limit |
| fail | output | 1 | Result over limit or timed out |
| timeoutErr | output | 1 | Digitizer did not respond in time |

## Verification
Codes below, equal to and one above the limit show the strict-greater comparison. Settling counts of 0, 1 and larger values show how the request is placed relative to the clock stop. Responses on the first and last cycle of the wait window, one cycle late, or missing entirely show where the window edges sit. A stray valid pulse and a repeated vector-loaded pulse during settling, together with a reset during settling, show that out-of-sequence inputs cannot disturb a measurement or keep the clock stopped.

// File: rtl/qcm_pkg.sv
package qcm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_STOP, ST_SETTLE, ST_SAMPLE, ST_WAIT, ST_CMP, ST_DONE
  } qcm_state_t;

  typedef struct packed {
    logic loadSettle;
    logic decSettle;
    logic clrWait;
    logic incWait;
    logic capture;
    logic markTimeout;
    logic clrResult;
    logic compare;
  } qcm_strobe_t;
endpackage

// File: rtl/qcm_datapath.sv
module qcm_datapath
  import qcm_pkg::*;
#(
  parameter int CNT_W = 24,
  parameter int CODE_W = 16,
  parameter int TIMEOUT_CYCLES = 1000,
  localparam int TO_W = $clog2(TIMEOUT_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  qcm_strobe_t       strobes,
  input  logic [CNT_W-1:0]  settleCycles,
  input  logic [CODE_W-1:0] limitCode,
  input  logic [CODE_W-1:0] sampleData,
  output logic              settleDone,
  output logic              waitExpired,
  output logic              pass,
  output logic              fail,
  output logic              timeoutErr
);
  logic [CNT_W-1:0]  settleCnt;
  logic [TO_W-1:0]   waitCnt;
  logic [CODE_W-1:0] codeReg;
  logic              toFlag;

  assign settleDone  = (settleCnt <= CNT_W'(1));
  assign waitExpired = (waitCnt == TO_W'(TIMEOUT_CYCLES - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      settleCnt  <= '0;
      waitCnt    <= '0;
      codeReg    <= '0;
      toFlag     <= 1'b0;
      pass       <= 1'b0;
      fail       <= 1'b0;
      timeoutErr <= 1'b0;
    end else begin
      if (strobes.loadSettle) settleCnt <= settleCycles;
      else if (strobes.decSettle) settleCnt <= settleCnt - CNT_W'(1);
      if (strobes.clrWait) waitCnt <= '0;
      else if (strobes.incWait) waitCnt <= waitCnt + TO_W'(1);
      if (strobes.capture) begin
        codeReg <= sampleData;
        toFlag  <= 1'b0;
      end else if (strobes.markTimeout) begin
        toFlag  <= 1'b1;
      end
      if (strobes.clrResult) begin
        pass <= 1'b0; fail <= 1'b0; timeoutErr <= 1'b0;
      end else if (strobes.compare) begin
        fail       <= toFlag || (codeReg > limitCode);
        pass       <= !(toFlag || (codeReg > limitCode));
        timeoutErr <= toFlag;
      end
    end
  end

  assert_result_excl_R4: assert property (@(posedge clk) disable iff (rst)
    $past(strobes.compare) |-> (pass ^ fail));
  assert_timeout_fails_R5: assert property (@(posedge clk) disable iff (rst)
    timeoutErr |-> fail);
  assert_cleared_on_stop_R6: assert property (@(posedge clk) disable iff (rst)
    strobes.clrResult |=> !pass && !fail && !timeoutErr);
endmodule

// File: rtl/qcm_ctrl.sv
module qcm_ctrl
  import qcm_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        vecLoaded,
  input  logic        sampleValid,
  input  logic        settleDone,
  input  logic        waitExpired,
  output qcm_strobe_t strobes,
  output logic        funcClkEn,
  output logic        sampleReq,
  output logic        done
);
  qcm_state_t state, stateNext;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobes   = '0;
    case (state)
      ST_IDLE:   if (vecLoaded) stateNext = ST_STOP;
      ST_STOP: begin
        strobes.loadSettle = 1'b1;
        strobes.clrResult  = 1'b1;
        stateNext = ST_SETTLE;
      end
      ST_SETTLE: begin
        if (settleDone) stateNext = ST_SAMPLE;
        else strobes.decSettle = 1'b1;
      end
      ST_SAMPLE: begin
        strobes.clrWait = 1'b1;
        stateNext = ST_WAIT;
      end
      ST_WAIT: begin
        if (sampleValid) begin
          strobes.capture = 1'b1;
          stateNext = ST_CMP;
        end else if (waitExpired) begin
          strobes.markTimeout = 1'b1;
          stateNext = ST_CMP;
        end else begin
          strobes.incWait = 1'b1;
        end
      end
      ST_CMP: begin
        strobes.compare = 1'b1;
        stateNext = ST_DONE;
      end
      ST_DONE:   stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  assign funcClkEn = (state == ST_IDLE);
  assign sampleReq = (state == ST_SAMPLE);
  assign done      = (state == ST_DONE);

  assert_start_stops_clk_R1: assert property (@(posedge clk) disable iff (rst)
    (funcClkEn && vecLoaded) |=> !funcClkEn);
  assert_req_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    sampleReq |=> !sampleReq && !funcClkEn);
  assert_done_reenables_R2: assert property (@(posedge clk) disable iff (rst)
    done |=> !done && funcClkEn);
  assert_clk_fall_only_on_start_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(funcClkEn) |-> $past(vecLoaded));
  assert_reset_idle_R7: assert property (@(posedge clk)
    rst |=> funcClkEn && !sampleReq && !done);
endmodule

// File: rtl/qcm_sequencer.sv
module qcm_sequencer
  import qcm_pkg::*;
#(
  parameter int CNT_W = 24,
  parameter int CODE_W = 16,
  parameter int TIMEOUT_CYCLES = 1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vecLoaded,
  input  logic [CNT_W-1:0]  settleCycles,
  input  logic [CODE_W-1:0] limitCode,
  input  logic [CODE_W-1:0] sampleData,
  input  logic              sampleValid,
  output logic              funcClkEn,
  output logic              sampleReq,
  output logic              done,
  output logic              pass,
  output logic              fail,
  output logic              timeoutErr
);
  qcm_strobe_t strobes;
  logic settleDone, waitExpired;

  qcm_ctrl u_ctrl (
    .clk(clk), .rst(rst), .vecLoaded(vecLoaded), .sampleValid(sampleValid),
    .settleDone(settleDone), .waitExpired(waitExpired), .strobes(strobes),
    .funcClkEn(funcClkEn), .sampleReq(sampleReq), .done(done)
  );

  qcm_datapath #(.CNT_W(CNT_W), .CODE_W(CODE_W), .TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_dp (
    .clk(clk), .rst(rst), .strobes(strobes), .settleCycles(settleCycles),
    .limitCode(limitCode), .sampleData(sampleData), .settleDone(settleDone),
    .waitExpired(waitExpired), .pass(pass), .fail(fail), .timeoutErr(timeoutErr)
  );

  assert_result_with_done_R6: assert property (@(posedge clk) disable iff (rst)
    done |-> (pass ^ fail));
endmodule

// File: tb/tb_qcm_sequencer.sv
module tb_qcm_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 24;
  localparam int CODE_W = 16;
  localparam int TO = 16;

  logic clk = 0, rst = 1, vecLoaded = 0, sampleValid = 0;
  logic [CNT_W-1:0] settleCycles = '0;
  logic [CODE_W-1:0] limitCode = 16'd75, sampleData = '0;
  logic funcClkEn, sampleReq, done, pass, fail, timeoutErr;

  int compared = 0, mismatched = 0, cycles = 0;

  qcm_sequencer #(.CNT_W(CNT_W), .CODE_W(CODE_W), .TIMEOUT_CYCLES(TO)) dut (
    .clk(clk), .rst(rst), .vecLoaded(vecLoaded), .settleCycles(settleCycles),
    .limitCode(limitCode), .sampleData(sampleData), .sampleValid(sampleValid),
    .funcClkEn(funcClkEn), .sampleReq(sampleReq), .done(done),
    .pass(pass), .fail(fail), .timeoutErr(timeoutErr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference: phase number plus integer counters
  int ph = 0, remain = 0, waited = 0, code = 0;
  bit noResp = 0, mPass = 0, mFail = 0, mTo = 0;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (rst) begin
      ph = 0; mPass = 0; mFail = 0; mTo = 0;
    end else begin
      case (ph)
        0: if (vecLoaded) ph = 1;
        1: begin mPass = 0; mFail = 0; mTo = 0; remain = int'(settleCycles); ph = 2; end
        2: if (remain <= 1) ph = 3; else remain--;
        3: begin waited = 0; ph = 4; end
        4: if (sampleValid) begin code = int'(sampleData); noResp = 0; ph = 5; end
           else if (waited == TO - 1) begin noResp = 1; ph = 5; end
           else waited++;
        5: begin mFail = noResp || (code > int'(limitCode)); mPass = !mFail; mTo = noResp; ph = 6; end
        default: ph = 0;
      endcase
    end
  end

  task automatic check(bit ok, string tag, int act, int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    check(funcClkEn == (ph == 0), "R2 funcClkEn", funcClkEn, ph == 0);
    check(sampleReq == (ph == 3), "R3 sampleReq", sampleReq, ph == 3);
    check(done == (ph == 6), "R6 done", done, ph == 6);
    check(pass == mPass, "R4 pass", pass, mPass);
    check(fail == mFail, "R4 fail", fail, mFail);
    check(timeoutErr == mTo, "R5 timeoutErr", timeoutErr, mTo);
  end

  always @(posedge clk) if (cycles > 100000) begin
    mismatched++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  // dly: negedges after the one showing sampleReq; <0 means no response
  task automatic runMeas(int s, int lim, int c, int dly, bit stray,
                         bit expFail, bit expTo, string tag);
    int reqAt, fallAt, n;
    settleCycles = CNT_W'(s);
    limitCode = CODE_W'(lim);
    @(negedge clk); vecLoaded = 1;
    @(negedge clk); vecLoaded = 0;
    fallAt = cycles;
    check(!funcClkEn, "R1 clock stop", funcClkEn, 0);
    if (stray) begin
      sampleValid = 1; sampleData = 16'hFFFF; vecLoaded = 1;
      @(negedge clk); sampleValid = 0; vecLoaded = 0;
    end
    n = 0;
    while (!sampleReq && n < 1000) begin @(negedge clk); n++; end
    reqAt = cycles;
    check(reqAt - fallAt == (s < 1 ? 1 : s) + 1, "R3 request position",
          reqAt - fallAt, (s < 1 ? 1 : s) + 1);
    if (dly >= 0) begin
      repeat (dly) @(negedge clk);
      sampleValid = 1; sampleData = CODE_W'(c);
      @(negedge clk); sampleValid = 0;
    end
    n = 0;
    while (!done && n < 1000) begin @(negedge clk); n++; end
    check(fail == expFail, {tag, " fail"}, fail, expFail);
    check(pass == !expFail, {tag, " pass"}, pass, !expFail);
    check(timeoutErr == expTo, "R5 timeout flag", timeoutErr, expTo);
    @(negedge clk);
    check(funcClkEn, "R2 clock re-enabled", funcClkEn, 1);
    repeat (3) @(negedge clk);
    check(funcClkEn && (fail == expFail), "R1 R6 idle hold", funcClkEn, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(funcClkEn && !sampleReq && !done && !pass && !fail && !timeoutErr,
          "R7 reset state", {funcClkEn, sampleReq, done, pass, fail, timeoutErr}, 6'b100000);
    rst = 0;
    @(negedge clk);
    runMeas(5, 75, 40, 1, 0, 0, 0, "R4 below limit");
    runMeas(3, 75, 75, 2, 0, 0, 0, "R4 equal limit");
    runMeas(3, 75, 76, 1, 0, 1, 0, "R4 above limit");
    runMeas(0, 10, 0, 1, 0, 0, 0, "R3 zero settle");
    runMeas(1, 10, 11, 3, 0, 1, 0, "R4 one settle");
    runMeas(4, 75, 20, TO, 0, 0, 0, "R5 last window cycle");
    runMeas(4, 75, 20, TO + 1, 0, 1, 1, "R5 one late");
    runMeas(2, 75, 20, -1, 0, 1, 1, "R5 no response");
    runMeas(6, 75, 30, 1, 1, 0, 0, "R5 stray valid ignored");
    // R7: reset mid-settle
    settleCycles = 24'd20;
    @(negedge clk); vecLoaded = 1;
    @(negedge clk); vecLoaded = 0;
    repeat (4) @(negedge clk);
    rst = 1;
    @(negedge clk); rst = 0;
    check(funcClkEn && !sampleReq && !done, "R7 reset mid-settle", funcClkEn, 1);
    repeat (30) @(negedge clk);
    check(funcClkEn && !sampleReq, "R7 stays idle", sampleReq, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule